// File: doc/BRIEF.md
# Memory Initialization Command Sequencer

This block replays a short, software-loaded list of memory commands onto the command pins of a DRAM PHY during power-up. Each slot of the list has two words. The first word holds the control pin encoding, the clock-enable level and the bank field. The second word holds an 11-bit address/mode value and the wait that must follow the command. Software writes the slots, writes the index of the final slot together with a valid flag, and sets a start bit. The sequencer then issues the slots in ascending order. Between commands it drives NOP.

Each wait is stored as its length in clocks minus two, so a stored value of zero gives the minimum spacing of two clocks. When the wait of the final slot has run out, the hardware clears the valid flag. Software watches for that and then sets a separate done bit, which the rest of the controller uses to allow normal traffic.

All registers are reached through a single-cycle write port. The valid flag and the done bit are also available as outputs.

Top module: `init_seq`

## Requirements
- R1: After reset the outputs are at rest. `mem_ctl` is NOP (4'b0111), and `mem_cke`, `mem_bank`, `mem_addr`, `cmd_valid` and `init_done` are all zero.
- R2: Issuing begins only when the valid flag and the start bit are both set while the sequencer is idle. The valid flag is bit 15 of the issue register at address 6'h01. The start bit is bit 0 of the control register at address 6'h00. Slot 0 appears on the outputs in the cycle after the write that completes this condition. While either is clear, the outputs stay at NOP.
- R3: Slot i has a command word at address 6'h10+i and an argument word at address 6'h20+i. In the command word, bits 3:0 are {cs_n, ras_n, cas_n, we_n}, bit 4 is clock enable and bits 10:8 are the bank. In the argument word, bits 10:0 are the address and bits 18:11 are the wait field. Each issued slot drives these fields for exactly one cycle.
- R4: The next slot is issued exactly wait field + 2 cycles after the previous one. In between, `mem_ctl` is NOP and `mem_bank` and `mem_addr` are zero. The wait field covers 0 to 255.
- R5: During NOP cycles, `mem_cke` holds the clock-enable level of the most recently issued slot.
- R6: Slots are issued from 0 upward. The last one issued is the slot named by bits 3:0 of the issue register. An index at or above the final table slot (11 for 12 slots) ends the run at the final slot.
- R7: `cmd_valid` drops at the point where the next slot would have been issued, which is wait field + 2 cycles after the final slot. The outputs then stay at NOP.
- R8: While a run is in progress, writes to any slot word and to the issue register are ignored.
- R9: Bit 1 of the control register drives `init_done`. This bit can be written at any time and does not affect issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Register write address |
| reg_wdata | input | 32 | Register write data |
| mem_ctl | output | 4 | {cs_n, ras_n, cas_n, we_n} to the PHY |
| mem_cke | output | 1 | Clock enable to the PHY |
| mem_bank | output | BA_W (3) | Bank address to the PHY |
| mem_addr | output | 11 | Address/mode value to the PHY |
| cmd_valid | output | 1 | Valid flag; cleared by hardware at the end of a run |
| init_done | output | 1 | Software-set flag that permits normal operation |

## Verification
The assertions assume that reset is held low from time zero, and that every register write is a single-cycle strobe with a stable address and data. They also assume the wait counter is only ever loaded from a slot's wait field, so every issued command is followed by at least one NOP. The bench drives all writes at the falling edge, one per cycle. It writes to the table and the issue register during a run only in the one test that checks those writes are ignored. Expected command streams are generated slot by slot from the programmed fields, using wait + 2 cycles per slot.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
   localparam int DATA_W   = 32;
   localparam int REG_AW   = 6;
   localparam int SLOT_IW  = 4;
   localparam int MA_W     = 11;
   localparam int CKE_BIT  = 4;
   localparam int BANK_LSB = 8;
   localparam int WAIT_LSB = MA_W;
   localparam int VALID_BIT = 15;
   localparam int START_BIT = 0;
   localparam int DONE_BIT  = 1;

   localparam logic [3:0]        CTL_NOP   = 4'b0111;
   localparam logic [REG_AW-1:0] RA_CTRL   = 6'h00;
   localparam logic [REG_AW-1:0] RA_ISSUE  = 6'h01;
   localparam logic [1:0]        RG_CMD    = 2'b01;
   localparam logic [1:0]        RG_ARG    = 2'b10;

   typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/init_seq_table.sv
module init_seq_table
   import init_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 12,
   parameter int BA_W      = 3,
   parameter int DLY_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                lock,
   input  logic [SLOT_IW-1:0]  rd_idx,
   output logic [3:0]          rd_ctl,
   output logic                rd_cke,
   output logic [BA_W-1:0]     rd_bank,
   output logic [MA_W-1:0]     rd_addr,
   output logic [DLY_W-1:0]    rd_dly
);
   logic [3:0]       s_ctl  [NUM_SLOTS];
   logic             s_cke  [NUM_SLOTS];
   logic [BA_W-1:0]  s_bank [NUM_SLOTS];
   logic [MA_W-1:0]  s_addr [NUM_SLOTS];
   logic [DLY_W-1:0] s_dly  [NUM_SLOTS];
   logic             unused_wdata;

   assign unused_wdata = ^wr_data;

   // one register pair per slot; writes are blocked while a run is active
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic             we_cmd, we_arg;
      logic [3:0]       ctl_q;
      logic             cke_q;
      logic [BA_W-1:0]  bank_q;
      logic [MA_W-1:0]  addr_q;
      logic [DLY_W-1:0] dly_q;

      assign we_cmd = wr_en && !lock && (wr_addr == {RG_CMD, SLOT_IW'(g)});
      assign we_arg = wr_en && !lock && (wr_addr == {RG_ARG, SLOT_IW'(g)});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_q  <= CTL_NOP;
            cke_q  <= 1'b0;
            bank_q <= '0;
            addr_q <= '0;
            dly_q  <= '0;
         end else begin
            if (we_cmd) begin
               ctl_q  <= wr_data[3:0];
               cke_q  <= wr_data[CKE_BIT];
               bank_q <= wr_data[BANK_LSB +: BA_W];
            end
            if (we_arg) begin
               addr_q <= wr_data[MA_W-1:0];
               dly_q  <= wr_data[WAIT_LSB +: DLY_W];
            end
         end
      end

      assign s_ctl[g]  = ctl_q;
      assign s_cke[g]  = cke_q;
      assign s_bank[g] = bank_q;
      assign s_addr[g] = addr_q;
      assign s_dly[g]  = dly_q;
   end

   always_comb begin
      rd_ctl  = s_ctl[0];
      rd_cke  = s_cke[0];
      rd_bank = s_bank[0];
      rd_addr = s_addr[0];
      rd_dly  = s_dly[0];
      for (int i = 1; i < NUM_SLOTS; i++) begin
         if (rd_idx == SLOT_IW'(i)) begin
            rd_ctl  = s_ctl[i];
            rd_cke  = s_cke[i];
            rd_bank = s_bank[i];
            rd_addr = s_addr[i];
            rd_dly  = s_dly[i];
         end
      end
   end
endmodule

// File: rtl/init_seq_regs.sv
module init_seq_regs
   import init_seq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                lock,
   input  logic                clr_valid,
   output logic                start_o,
   output logic                done_o,
   output logic                valid_o,
   output logic [SLOT_IW-1:0]  last_o
);
   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         done_o  <= 1'b0;
         valid_o <= 1'b0;
         last_o  <= '0;
      end else begin
         if (wr_en && wr_addr == RA_CTRL) begin
            start_o <= wr_data[START_BIT];
            done_o  <= wr_data[DONE_BIT];
         end
         if (clr_valid) begin
            valid_o <= 1'b0;
         end else if (wr_en && !lock && wr_addr == RA_ISSUE) begin
            valid_o <= wr_data[VALID_BIT];
            last_o  <= wr_data[SLOT_IW-1:0];
         end
      end
   end
endmodule

// File: rtl/init_seq_engine.sv
module init_seq_engine
   import init_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 12,
   parameter int BA_W      = 3,
   parameter int DLY_W     = 8,
   localparam int CNT_W    = DLY_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                start,
   input  logic [SLOT_IW-1:0]  last,
   input  logic [3:0]          rd_ctl,
   input  logic                rd_cke,
   input  logic [BA_W-1:0]     rd_bank,
   input  logic [MA_W-1:0]     rd_addr,
   input  logic [DLY_W-1:0]    rd_dly,
   output logic [SLOT_IW-1:0]  rd_idx,
   output logic                busy,
   output logic                clr_valid,
   output logic                issue,
   output logic [CNT_W-1:0]    wait_cnt,
   output logic [3:0]          mem_ctl,
   output logic                mem_cke,
   output logic [BA_W-1:0]     mem_bank,
   output logic [MA_W-1:0]     mem_addr
);
   localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NUM_SLOTS - 1);

   seq_state_e         state_q;
   logic [SLOT_IW-1:0] idx_q;
   logic [SLOT_IW-1:0] last_eff;
   logic               running, expired, take;

   assign running   = (state_q == ST_RUN);
   assign last_eff  = (last >= LAST_SLOT) ? LAST_SLOT : last;
   assign rd_idx    = running ? idx_q + SLOT_IW'(1) : '0;
   assign expired   = running && (wait_cnt == '0);
   assign clr_valid = expired && (idx_q == last_eff);
   assign take      = (!running && valid && start) || (expired && idx_q != last_eff);
   assign busy      = running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         wait_cnt <= '0;
         issue    <= 1'b0;
         mem_ctl  <= CTL_NOP;
         mem_cke  <= 1'b0;
         mem_bank <= '0;
         mem_addr <= '0;
      end else if (take) begin
         state_q  <= ST_RUN;
         idx_q    <= rd_idx;
         wait_cnt <= CNT_W'(rd_dly) + CNT_W'(1);
         issue    <= 1'b1;
         mem_ctl  <= rd_ctl;
         mem_cke  <= rd_cke;
         mem_bank <= rd_bank;
         mem_addr <= rd_addr;
      end else begin
         issue    <= 1'b0;
         mem_ctl  <= CTL_NOP;
         mem_bank <= '0;
         mem_addr <= '0;
         if (running && wait_cnt != '0) wait_cnt <= wait_cnt - CNT_W'(1);
         if (clr_valid) state_q <= ST_IDLE;
      end
   end
endmodule

// File: rtl/init_seq.sv
module init_seq
   import init_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 12,
   parameter int BA_W      = 3,
   parameter int DLY_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [5:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [3:0]         mem_ctl,
   output logic               mem_cke,
   output logic [BA_W-1:0]    mem_bank,
   output logic [10:0]        mem_addr,
   output logic               cmd_valid,
   output logic               init_done
);
   localparam int CNT_W = DLY_W + 1;

   if (NUM_SLOTS < 2 || NUM_SLOTS > (1 << SLOT_IW)) begin : g_bad_slots
      $error("init_seq: NUM_SLOTS must lie in 2..16");
   end
   if (WAIT_LSB + DLY_W > DATA_W) begin : g_bad_dly
      $error("init_seq: wait field does not fit the argument word");
   end
   if (BA_W < 1 || BA_W > 8) begin : g_bad_bank
      $error("init_seq: BA_W must lie in 1..8");
   end

   logic               busy, clr_valid, issue, start, valid;
   logic [SLOT_IW-1:0] last_idx, rd_idx;
   logic [CNT_W-1:0]   wait_cnt;
   logic [3:0]         rd_ctl;
   logic               rd_cke;
   logic [BA_W-1:0]    rd_bank;
   logic [MA_W-1:0]    rd_addr;
   logic [DLY_W-1:0]   rd_dly;

   init_seq_table #(.NUM_SLOTS(NUM_SLOTS), .BA_W(BA_W), .DLY_W(DLY_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .lock(busy), .rd_idx(rd_idx), .rd_ctl(rd_ctl), .rd_cke(rd_cke),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_dly(rd_dly)
   );

   init_seq_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .lock(busy), .clr_valid(clr_valid), .start_o(start), .done_o(init_done),
      .valid_o(valid), .last_o(last_idx)
   );

   init_seq_engine #(.NUM_SLOTS(NUM_SLOTS), .BA_W(BA_W), .DLY_W(DLY_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .valid(valid), .start(start), .last(last_idx),
      .rd_ctl(rd_ctl), .rd_cke(rd_cke), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .rd_dly(rd_dly), .rd_idx(rd_idx), .busy(busy), .clr_valid(clr_valid),
      .issue(issue), .wait_cnt(wait_cnt), .mem_ctl(mem_ctl), .mem_cke(mem_cke),
      .mem_bank(mem_bank), .mem_addr(mem_addr)
   );

   assign cmd_valid = valid;
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             issue,
   input logic [CNT_W-1:0] wait_cnt,
   input logic             valid,
   input logic             start,
   input logic [3:0]       last_idx,
   input logic [3:0]       mem_ctl,
   input logic             mem_cke
);
   // R2: a run only begins from a set valid flag and start bit
   a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(valid && start));

   // R4: an issued command lasts one cycle
   a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);

   // R4: no command while the wait is still counting
   a_r4_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wait_cnt != '0) |=> !issue);

   // R5: clock enable only moves when a slot is issued
   a_r5_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> $stable(mem_cke));

   // R7: end of a run clears the valid flag, idle drives NOP
   a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !valid);
   a_r7_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> mem_ctl == 4'b0111);

   // R8: the last-slot index cannot change during a run
   a_r8_last_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(last_idx));
endmodule

bind init_seq init_seq_chk #(.CNT_W(DLY_W + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .issue(issue), .wait_cnt(wait_cnt),
   .valid(valid), .start(start), .last_idx(last_idx), .mem_ctl(mem_ctl),
   .mem_cke(mem_cke)
);

// File: tb/tb_init_seq.sv
`timescale 1ns/1ps
module tb_init_seq;
   localparam int NS = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  mem_ctl;
   logic        mem_cke;
   logic [2:0]  mem_bank;
   logic [10:0] mem_addr;
   logic        cmd_valid, init_done;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   int e_ctl [NS];
   int e_cke [NS];
   int e_bank[NS];
   int e_addr[NS];
   int e_dly [NS];

   always #2.5 clk = ~clk;

   init_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_ctl(mem_ctl), .mem_cke(mem_cke),
      .mem_bank(mem_bank), .mem_addr(mem_addr), .cmd_valid(cmd_valid),
      .init_done(init_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 32'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic load_slot(input int k, input int ctl, input int cke,
                            input int bank, input int addr, input int dly);
      e_ctl[k] = ctl; e_cke[k] = cke; e_bank[k] = bank; e_addr[k] = addr; e_dly[k] = dly;
      wr(6'h10 + k, (bank << 8) | (cke << 4) | ctl);
      wr(6'h20 + k, (dly << 11) | addr);
   endtask

   task automatic idle_nop(input string req, input int n, input int vexp);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk({req, " idle ctl"}, mem_ctl, 4'b0111);
         chk({req, " valid"}, cmd_valid, vexp);
      end
   endtask

   // expected stream: slot k for 1 cycle, then e_dly[k]+1 NOP cycles
   task automatic run_check(input int last_req, input bit poke);
      int last_eff = (last_req >= NS - 1) ? NS - 1 : last_req;
      int cyc = 0;
      for (int k = 0; k <= last_eff; k++) begin
         for (int w = 0; w <= e_dly[k] + 1; w++) begin
            @(negedge clk);
            if (w == 0) begin
               chk("R3 ctl", mem_ctl, e_ctl[k]);
               chk("R3 bank", mem_bank, e_bank[k]);
               chk("R6 addr order", mem_addr, e_addr[k]);
            end else begin
               chk("R4 nop ctl", mem_ctl, 4'b0111);
               chk("R4 nop bank/addr", {mem_bank, mem_addr}, 0);
            end
            chk("R5 cke", mem_cke, e_cke[k]);
            chk("R7 valid held", cmd_valid, 1);
            reg_wr = 1'b0;
            if (poke && cyc < 3) begin
               reg_wr = 1'b1;
               case (cyc)
                  0: begin reg_addr = 6'h15; reg_wdata = 32'h0000_0512; end
                  1: begin reg_addr = 6'h25; reg_wdata = 32'h0000_07FF; end
                  default: begin reg_addr = 6'h01; reg_wdata = 32'h0000_8000; end
               endcase
            end
            cyc++;
         end
      end
      @(negedge clk);
      chk("R7 valid cleared", cmd_valid, 0);
      chk("R7 nop after run", mem_ctl, 4'b0111);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ctl", mem_ctl, 4'b0111);
      chk("R1 cke", mem_cke, 0);
      chk("R1 bank/addr", {mem_bank, mem_addr}, 0);
      chk("R1 valid", cmd_valid, 0);
      chk("R1 done", init_done, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // typical power-up program
      load_slot(0,  4'b0111, 1, 0, 11'h000, 78);
      load_slot(1,  4'b0010, 1, 0, 11'h400, 3);
      load_slot(2,  4'b0000, 1, 2, 11'h000, 0);
      load_slot(3,  4'b0000, 1, 3, 11'h000, 0);
      load_slot(4,  4'b0000, 1, 1, 11'h040, 0);
      load_slot(5,  4'b0000, 1, 0, 11'h153, 0);
      load_slot(6,  4'b0010, 1, 0, 11'h400, 3);
      load_slot(7,  4'b0001, 1, 0, 11'h000, 25);
      load_slot(8,  4'b0001, 1, 0, 11'h000, 25);
      load_slot(9,  4'b0000, 1, 0, 11'h053, 0);
      load_slot(10, 4'b0000, 1, 1, 11'h3C0, 0);
      load_slot(11, 4'b0000, 1, 1, 11'h040, 26);

      // R2: valid without start does nothing
      wr(6'h01, 32'h8000 | 11);
      idle_nop("R2 no start", 5, 1);
      wr(6'h00, 32'h1);
      run_check(11, 0);

      // R3 R4 R6: sweep of last index with varied fields
      for (int last = 0; last < NS; last++) begin
         for (int k = 0; k < NS; k++)
            load_slot(k, (k + last) % 16, (k + last) & 1, (k + last) % 8,
                      (k * 131 + last * 17) & 11'h7FF, (k * 7 + last * 3) % 6);
         wr(6'h01, 32'h8000 | last);
         run_check(last, 0);
      end

      // R6: index beyond the table clamps to the final slot
      wr(6'h01, 32'h8000 | 15);
      run_check(15, 0);
      wr(6'h01, 32'h8000 | 13);
      run_check(13, 0);

      // R2: start set but valid clear
      wr(6'h01, 32'h0000 | 5);
      idle_nop("R2 no valid", 4, 0);

      // R8: writes during a run are ignored, then the same stream replays
      wr(6'h01, 32'h8000 | 11);
      run_check(11, 1);
      wr(6'h01, 32'h8000 | 11);
      run_check(11, 0);

      // R4: maximum wait field
      load_slot(0, 4'b0010, 0, 5, 11'h7FF, 255);
      wr(6'h01, 32'h8000);
      run_check(0, 0);

      // R9: done bit, independent of issuing
      wr(6'h00, 32'h2);
      @(negedge clk);
      chk("R9 done set", init_done, 1);
      wr(6'h01, 32'h8000 | 3);
      idle_nop("R9 done does not start", 4, 1);
      wr(6'h00, 32'h3);
      run_check(3, 0);
      chk("R9 done kept", init_done, 1);
      wr(6'h00, 32'h0);
      @(negedge clk);
      chk("R9 done cleared", init_done, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule